// File: doc/BRIEF.md
# Flat Panel Power Sequencer

This block brings an attached flat panel up and down in a fixed order, driven by one enable level. When the enable rises, four stages switch on one after another: the panel supply, then the panel signal stage (pixel clock enable, syncs and pixel data bus), then the LCD bias, and last the backlight. When the enable falls, the same stages switch off with the backlight first and the supply last. If the enable changes direction part way through, the machine turns around from the stage it has reached. It does not finish the old sequence first.

The gap between two stage changes is set by a delay input. That value counts pulses of a slow tick enable that the surrounding logic provides. The panel syncs, pixel clock enable and pixel bus pass through a gate, which drives them only while the signal stage is on. The pixel path is a plain combinational pass-through with no valid/ready handshake. It never applies back-pressure and adds no latency. The source must keep presenting data whether or not the panel accepts it. A two-bit status output lets software poll for completion.

Top module: `fp_pwr_seq`

## Requirements
- R1: After reset, all four stage outputs are low and status is 0. An enable already high when reset releases starts nothing: a new low-to-high change is needed.
- R2: On a rising enable, the stages turn on one at a time in this order: supply (`vdd_on`), signals (`sig_on`), bias (`bias_on`), backlight (`bl_on`). A later stage is never on while an earlier one is off.
- R3: On a falling enable, the stages turn off one at a time in the reverse order: backlight, bias, signals, supply.
- R4: With delay value D on `step_dly`, each stage change happens on the (D+1)th `tick` pulse counted after the previous change or after the enable edge. A tick in the same cycle as an enable edge is not counted. D = 0 gives one stage per tick.
- R5: A stage output changes only on a clock edge at which `tick` was high.
- R6: An enable reversal during a sequence turns the machine around from its current stage and restarts the delay count.
- R7: `fp_hs`, `fp_vs`, `fp_clk_en` and `fp_pix` follow `hs_in`, `vs_in`, `sig_on` and `pix_in` in the same cycle while the signal stage is on, and are all low while it is off.
- R8: `status` is 0 when the panel is fully off and idle, 2 when the panel is fully on with the enable high, and 1 otherwise (sequencing).
- R9: While the enable level stays constant and the sequence has completed, no stage output changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Slow time-base pulse, one clock wide |
| pwr_en | input | 1 | Panel power enable level |
| step_dly | input | CNT_W | Ticks per stage step, minus one |
| hs_in | input | 1 | Panel horizontal sync from the timing generator |
| vs_in | input | 1 | Panel vertical sync from the timing generator |
| pix_in | input | PIX_W | Panel pixel data from the pipeline |
| vdd_on | output | 1 | Panel supply stage |
| sig_on | output | 1 | Signal stage |
| bias_on | output | 1 | LCD bias stage |
| bl_on | output | 1 | Backlight stage |
| fp_clk_en | output | 1 | Panel pixel clock enable (gated) |
| fp_hs | output | 1 | Gated horizontal sync |
| fp_vs | output | 1 | Gated vertical sync |
| fp_pix | output | PIX_W | Gated pixel bus |
| status | output | 2 | 0 off, 1 sequencing, 2 on |

## Verification
The hardest case is a reversal at a known stage. The enable has to flip after a given stage has been reached and before the next step can occur. The stimulus pushes only the partial sequence into the scoreboard, waits until the monitor has consumed it, and flips the enable at once. With a delay of several ticks, the flip lands well inside the next step window. A reversal in each direction is covered this way. The tick count measured from the flipping edge confirms that the delay count restarts.

// File: rtl/fpps_pkg.sv
package fpps_pkg;
  localparam int unsigned NSTG  = 4;
  localparam int unsigned LVL_W = $clog2(NSTG + 1);

  typedef enum logic [1:0] {
    ST_OFF = 2'd0,
    ST_SEQ = 2'd1,
    ST_ON  = 2'd2
  } fp_stat_e;
endpackage

// File: rtl/fpps_edge.sv
module fpps_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_in,
  output logic rise,
  output logic fall
);
  logic prev_q;

  // Preset high: an enable already high at reset release is not a rise.
  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= lvl_in;
  end

  assign rise = lvl_in & ~prev_q;
  assign fall = ~lvl_in & prev_q;
endmodule

// File: rtl/fpps_timer.sv
module fpps_timer #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             busy,
  input  logic             tick,
  input  logic [CNT_W-1:0] dly,
  output logic             step
);
  logic [CNT_W-1:0] cnt_q;

  assign step = busy & tick & ~restart & (cnt_q >= dly);

  always_ff @(posedge clk) begin
    if (!rst_n)                      cnt_q <= '0;
    else if (restart || !busy || step) cnt_q <= '0;
    else if (tick)                   cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/fpps_ctrl.sv
module fpps_ctrl
  import fpps_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rise,
  input  logic            fall,
  input  logic            step,
  output logic            busy,
  output logic [NSTG-1:0] stage,
  output fp_stat_e        stat
);
  logic             up_q;
  logic [LVL_W-1:0] lvl_q;
  logic [LVL_W-1:0] target;

  always_ff @(posedge clk) begin
    if (!rst_n)    up_q <= 1'b0;
    else if (rise) up_q <= 1'b1;
    else if (fall) up_q <= 1'b0;
  end

  assign target = up_q ? LVL_W'(NSTG) : '0;
  assign busy   = (lvl_q != target);

  always_ff @(posedge clk) begin
    if (!rst_n)    lvl_q <= '0;
    else if (step) lvl_q <= up_q ? lvl_q + 1'b1 : lvl_q - 1'b1;
  end

  for (genvar i = 0; i < NSTG; i++) begin : g_dec
    assign stage[i] = (lvl_q > LVL_W'(i));
  end

  always_comb begin
    if (!busy && !up_q)     stat = ST_OFF;
    else if (!busy && up_q) stat = ST_ON;
    else                    stat = ST_SEQ;
  end
endmodule

// File: rtl/fpps_gate.sv
module fpps_gate #(
  parameter int unsigned PIX_W = 18
) (
  input  logic             sig_on,
  input  logic             hs_in,
  input  logic             vs_in,
  input  logic [PIX_W-1:0] pix_in,
  output logic             clk_en,
  output logic             hs_out,
  output logic             vs_out,
  output logic [PIX_W-1:0] pix_out
);
  assign clk_en = sig_on;
  assign hs_out = hs_in & sig_on;
  assign vs_out = vs_in & sig_on;

  for (genvar b = 0; b < PIX_W; b++) begin : g_pix
    assign pix_out[b] = pix_in[b] & sig_on;
  end
endmodule

// File: rtl/fp_pwr_seq.sv
module fp_pwr_seq
  import fpps_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned PIX_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             pwr_en,
  input  logic [CNT_W-1:0] step_dly,
  input  logic             hs_in,
  input  logic             vs_in,
  input  logic [PIX_W-1:0] pix_in,
  output logic             vdd_on,
  output logic             sig_on,
  output logic             bias_on,
  output logic             bl_on,
  output logic             fp_clk_en,
  output logic             fp_hs,
  output logic             fp_vs,
  output logic [PIX_W-1:0] fp_pix,
  output logic [1:0]       status
);
  logic            en_rise, en_fall, busy, step;
  logic [NSTG-1:0] stage;
  fp_stat_e        stat;

  fpps_edge u_edge (
    .clk(clk), .rst_n(rst_n), .lvl_in(pwr_en), .rise(en_rise), .fall(en_fall)
  );

  fpps_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .restart(en_rise | en_fall), .busy(busy),
    .tick(tick), .dly(step_dly), .step(step)
  );

  fpps_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .rise(en_rise), .fall(en_fall), .step(step),
    .busy(busy), .stage(stage), .stat(stat)
  );

  assign vdd_on  = stage[0];
  assign sig_on  = stage[1];
  assign bias_on = stage[2];
  assign bl_on   = stage[3];
  assign status  = stat;

  fpps_gate #(.PIX_W(PIX_W)) u_gate (
    .sig_on(stage[1]), .hs_in(hs_in), .vs_in(vs_in), .pix_in(pix_in),
    .clk_en(fp_clk_en), .hs_out(fp_hs), .vs_out(fp_vs), .pix_out(fp_pix)
  );
endmodule

// File: rtl/fp_pwr_seq_chk.sv
module fp_pwr_seq_chk #(
  parameter int unsigned PIX_W = 18
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             hs_in,
  input logic             vs_in,
  input logic [PIX_W-1:0] pix_in,
  input logic             vdd_on,
  input logic             sig_on,
  input logic             bias_on,
  input logic             bl_on,
  input logic             fp_clk_en,
  input logic             fp_hs,
  input logic             fp_vs,
  input logic [PIX_W-1:0] fp_pix,
  input logic [1:0]       status
);
  logic [3:0] stg;
  assign stg = {bl_on, bias_on, sig_on, vdd_on};

  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (stg == 4'b0000));

  a_r2_thermometer: assert property (@(posedge clk) disable iff (!rst_n)
    (!bl_on || bias_on) && (!bias_on || sig_on) && (!sig_on || vdd_on));

  a_r4_one_step: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(stg) |-> ($countones(stg ^ $past(stg)) == 1));

  a_r5_tick_only: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(stg) |-> $past(tick));

  a_r7_gate_off: assert property (@(posedge clk) disable iff (!rst_n)
    !sig_on |-> (fp_pix == '0 && !fp_hs && !fp_vs && !fp_clk_en));

  a_r7_gate_on: assert property (@(posedge clk) disable iff (!rst_n)
    sig_on |-> (fp_pix == pix_in && fp_hs == hs_in && fp_vs == vs_in && fp_clk_en));

  a_r8_status_off: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 2'd0) |-> (stg == 4'b0000));

  a_r8_status_on: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 2'd2) |-> (stg == 4'b1111));
endmodule

bind fp_pwr_seq fp_pwr_seq_chk #(.PIX_W(PIX_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .tick(tick), .hs_in(hs_in), .vs_in(vs_in),
  .pix_in(pix_in), .vdd_on(vdd_on), .sig_on(sig_on), .bias_on(bias_on),
  .bl_on(bl_on), .fp_clk_en(fp_clk_en), .fp_hs(fp_hs), .fp_vs(fp_vs),
  .fp_pix(fp_pix), .status(status)
);

// File: tb/fp_pwr_seq_tb_top.sv
module fp_pwr_seq_tb_top;
  localparam int CNT_W = 16;
  localparam int PIX_W = 18;
  localparam int TP    = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             tick = 1'b0;
  logic             pwr_en = 1'b1;
  logic [CNT_W-1:0] step_dly = 16'd2;
  logic             hs_in = 1'b0;
  logic             vs_in = 1'b0;
  logic [PIX_W-1:0] pix_in = '0;
  logic             vdd_on, sig_on, bias_on, bl_on, fp_clk_en, fp_hs, fp_vs;
  logic [PIX_W-1:0] fp_pix;
  logic [1:0]       status;

  int n_chk  = 0;
  int n_fail = 0;
  int cur_dly = 2;
  logic [3:0] exp_q[$];

  always #4 clk = ~clk;

  fp_pwr_seq #(.CNT_W(CNT_W), .PIX_W(PIX_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .pwr_en(pwr_en), .step_dly(step_dly),
    .hs_in(hs_in), .vs_in(vs_in), .pix_in(pix_in), .vdd_on(vdd_on),
    .sig_on(sig_on), .bias_on(bias_on), .bl_on(bl_on), .fp_clk_en(fp_clk_en),
    .fp_hs(fp_hs), .fp_vs(fp_vs), .fp_pix(fp_pix), .status(status)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Tick and data stimulus: one tick every TP cycles, changing pixel pattern.
  initial begin
    int tc = 0;
    forever begin
      @(posedge clk); #1;
      tick  = (tc == TP - 1);
      tc    = (tc == TP - 1) ? 0 : tc + 1;
      pix_in = pix_in * 5 + 18'h0_1a3;
      hs_in = ~hs_in;
      vs_in = pix_in[3];
    end
  end

  // Monitor: pops expected stage vectors as changes appear.
  logic [3:0] last_v = 4'b0000;
  bit en_seen = 1'b1, pend_t = 1'b0, pend_e = 1'b0;
  int tcnt = 0;
  always @(negedge clk) begin
    logic [3:0] now_v;
    logic [3:0] e;
    if (!rst_n) begin
      en_seen = 1'b1; pend_t = 1'b0; pend_e = 1'b0; tcnt = 0; last_v = 4'b0000;
    end else begin
      if (pend_e) tcnt = 0;
      else if (pend_t) tcnt++;
      now_v = {bl_on, bias_on, sig_on, vdd_on};
      if (now_v != last_v) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R9 unexpected stage change", int'(now_v), int'(last_v));
        end else begin
          e = exp_q.pop_front();
          chk(now_v == e, "R2/R3/R6 stage vector", int'(now_v), int'(e));
          chk(tcnt == cur_dly + 1, "R4 ticks per step", tcnt, cur_dly + 1);
          chk(fp_pix == (sig_on ? pix_in : '0), "R7 pixel gating at step",
              int'(fp_pix), int'(sig_on ? pix_in : '0));
        end
        tcnt = 0;
        last_v = now_v;
      end
      pend_e  = (pwr_en != en_seen);
      pend_t  = tick;
      en_seen = pwr_en;
    end
  end

  task automatic drive_en(input bit v);
    @(posedge clk); #1;
    pwr_en = v;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic full_up();
    exp_q.push_back(4'b0001); exp_q.push_back(4'b0011);
    exp_q.push_back(4'b0111); exp_q.push_back(4'b1111);
    drive_en(1'b1);
    @(negedge clk); @(negedge clk);
    chk(status == 2'd1, "R8 status sequencing", int'(status), 1);
    drain();
    chk(status == 2'd2, "R8 status on", int'(status), 2);
    chk(fp_pix == pix_in && fp_hs == hs_in && fp_clk_en, "R7 pass when on",
        int'(fp_pix), int'(pix_in));
  endtask

  task automatic full_down();
    exp_q.push_back(4'b0111); exp_q.push_back(4'b0011);
    exp_q.push_back(4'b0001); exp_q.push_back(4'b0000);
    drive_en(1'b0);
    drain();
    chk(status == 2'd0, "R3 status off after down", int'(status), 0);
    chk(fp_pix == '0 && !fp_hs && !fp_vs && !fp_clk_en, "R7 gated when off",
        int'(fp_pix), 0);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired R1-wide run hung actual=0 expected=1");
    finish_run();
  end

  initial begin
    // R1: enable high through reset must not start a sequence.
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (40) @(negedge clk);
    chk({bl_on, bias_on, sig_on, vdd_on} == 4'b0000, "R1 stages off after reset",
        int'({bl_on, bias_on, sig_on, vdd_on}), 0);
    chk(status == 2'd0, "R1 status off after reset", int'(status), 0);
    chk(fp_pix == '0 && !fp_clk_en, "R7 gated after reset", int'(fp_pix), 0);

    drive_en(1'b0);
    repeat (20) @(negedge clk);
    chk(status == 2'd0, "R1 falling with nothing on", int'(status), 0);

    // R2, R3 with D = 2
    full_up();
    repeat (60) @(negedge clk);
    chk({bl_on, bias_on, sig_on, vdd_on} == 4'b1111, "R9 held on",
        int'({bl_on, bias_on, sig_on, vdd_on}), 15);
    full_down();

    // R4 boundary: D = 0
    step_dly = 16'd0; cur_dly = 0;
    full_up();
    full_down();

    // R6: reversal during power-up after signal stage, D = 5
    step_dly = 16'd5; cur_dly = 5;
    exp_q.push_back(4'b0001); exp_q.push_back(4'b0011);
    drive_en(1'b1);
    drain();
    exp_q.push_back(4'b0001); exp_q.push_back(4'b0000);
    drive_en(1'b0);
    drain();
    chk(status == 2'd0, "R6 reversed up ends off", int'(status), 0);

    // R6: reversal during power-down after backlight off
    full_up();
    exp_q.push_back(4'b0111);
    drive_en(1'b0);
    drain();
    chk(status == 2'd1, "R6 mid-down status sequencing", int'(status), 1);
    exp_q.push_back(4'b1111);
    drive_en(1'b1);
    drain();
    chk(status == 2'd2, "R6 reversed down ends on", int'(status), 2);
    full_down();

    repeat (30) @(negedge clk);
    chk(exp_q.size() == 0, "R9 scoreboard empty", exp_q.size(), 0);
    finish_run();
  end
endmodule